// File: doc/BRIEF.md
# Dataway Command Decoder and Readout Sequencer

This block sits between a crate dataway and a bank of 32 latching 24-bit counters. It accepts one bus command at a time and runs it through two phases. The first phase decodes the function code and presents the read word together with the X (command accepted) and Q (condition true) replies. The second phase is the strobe point where the command takes effect. Effects include advancing the readout pointer, clearing the attention flag, and pulsing load, clear or test requests to the counter core. Host software can read one channel at the pointer again and again (random read, function 0). It can also walk through the channels with a read that advances the pointer (function 2), beginning at a start subaddress set in advance.

The counter core supplies `chan_data` for the channel named on `rd_chan`. A snapshot, whether requested by a control-word write (function 16) or by the external `ext_load_i` line, copies the preset start subaddress into the pointer and marks data as available. Reads reply Q=1 only after a snapshot exists and while the pointer still names one of the 32 channels. The broadcast initialize and clear lines are taken as commands of their own and need no station select.

The sequencer is a three-state machine. `PH_IDLE` waits for a request. The *accept* transition to `PH_ONE` happens when `cyc_start` is high together with `stn_sel`, `init_z` or `clr_c`. The *advance* transition takes `PH_ONE` to `PH_TWO` unconditionally. The *retire* transition takes `PH_TWO` back to `PH_IDLE`, and state updates land on that edge.

Top module: `dataway_readout_ctrl`

## Requirements
- R1: After reset the block is idle, with x=0, q=0, rd_data=0, rd_chan=0, lam_o=0, no command pulse, and cnt_inhibit equal to inhibit_i.
- R2: A request (cyc_start with stn_sel, init_z or clr_c) is accepted only in PH_IDLE. Function, write word and line levels are captured on that edge. Replies hold for exactly the two following cycles (PH_ONE, PH_TWO). Updates take effect on the edge that ends PH_TWO. Requests made while busy are ignored.
- R3: On a station cycle without init or clear, x=1 for function codes 0, 2, 8, 10 and 16, and x=0 for every other code.
- R4: Function 0 drives rd_data=chan_data. It replies q=1 only if a snapshot has occurred since the last initialize and the pointer is below 32. The pointer is left unchanged.
- R5: Function 2 reads and replies like function 0. It then advances the pointer by one if the pointer is below 32, and holds it at 32 otherwise. rd_chan shows the low 5 pointer bits.
- R6: Function 16 replies q=1 and stores wdata[4:0] as the start subaddress. If wdata[8] is set, it pulses load_p in PH_TWO, copies the new start value into the pointer, sets the snapshot flag, and sets LAM if LAM is enabled.
- R7: Function 16 with wdata[9] pulses clear_p. With wdata[11] it pulses test_p and holds cnt_inhibit high until an initialize or clear command.
- R8: Function 16 with wdata[10] copies the new start value into the pointer and enables LAM. When wdata[10] and wdata[8] are both set, the LAM enabled by this word applies to the load it triggers.
- R9: Functions 8 and 10 reply q=lam_o. Function 10 also clears LAM.
- R10: An initialize cycle replies x=q=0 and pulses clear_p. It zeroes the pointer, the start subaddress, the snapshot flag, LAM, LAM enable and test inhibit.
- R11: A clear cycle replies x=q=0, pulses clear_p and ends test inhibit. The pointer and flags are left unchanged.
- R12: Unsupported function codes and cycles without station select, initialize or clear have no effect on any state or output.
- R13: ext_load_i, in any cycle, copies the start subaddress into the pointer, sets the snapshot flag, and sets LAM if LAM is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cyc_start | input | 1 | Begins a dataway cycle |
| stn_sel | input | 1 | Station addressed |
| func | input | 5 | Function code |
| wdata | input | 24 | Write word |
| init_z | input | 1 | Broadcast initialize |
| clr_c | input | 1 | Broadcast clear |
| inhibit_i | input | 1 | Dataway inhibit level |
| ext_load_i | input | 1 | External snapshot pulse |
| chan_data | input | 24 | Latched word of channel rd_chan |
| rd_chan | output | 5 | Channel index presented to the core |
| rd_data | output | 24 | Read word on the bus |
| x | output | 1 | Command accepted |
| q | output | 1 | Condition reply |
| busy | output | 1 | Cycle in progress |
| load_p | output | 1 | Snapshot request to core |
| clear_p | output | 1 | Counter clear request to core |
| test_p | output | 1 | Test increment request to core |
| cnt_inhibit | output | 1 | Counting inhibit to core |
| lam_o | output | 1 | Attention request |

## Verification
A wrong pointer shows on rd_chan on the clock after the retiring edge. It also shows in the rd_data of the next read, so a lost or doubled increment appears within one command. A wrong snapshot flag or end-of-range test shows as a wrong Q on the next read. That is why the bench walks the pointer across channel 31 and reads at 32. Stale LAM or test-inhibit state shows at once on lam_o and cnt_inhibit, which the bench compares against its model on every clock.

// File: rtl/dwr_pkg.sv
package dwr_pkg;
    localparam int FN_W      = 5;
    localparam int LOAD_BIT  = 8;
    localparam int CLR_BIT   = 9;
    localparam int PREP_BIT  = 10;
    localparam int TEST_BIT  = 11;

    localparam logic [FN_W-1:0] FN_READ   = 5'd0;
    localparam logic [FN_W-1:0] FN_RSEQ   = 5'd2;
    localparam logic [FN_W-1:0] FN_LTEST  = 5'd8;
    localparam logic [FN_W-1:0] FN_LCLR   = 5'd10;
    localparam logic [FN_W-1:0] FN_CTRL   = 5'd16;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ONE  = 2'd1,
        PH_TWO  = 2'd2
    } phase_t;

    typedef struct packed {
        logic known;
        logic rd;
        logic rd_seq;
        logic lam_tst;
        logic lam_clr;
        logic wr_ctl;
    } fdec_t;
endpackage

// File: rtl/dwr_func_decode.sv
module dwr_func_decode
    import dwr_pkg::*;
(
    input  logic [FN_W-1:0] fn,
    output fdec_t           dec
);
    always_comb begin
        dec = '0;
        unique case (fn)
            FN_READ:  begin dec.known = 1'b1; dec.rd = 1'b1; end
            FN_RSEQ:  begin dec.known = 1'b1; dec.rd = 1'b1; dec.rd_seq = 1'b1; end
            FN_LTEST: begin dec.known = 1'b1; dec.lam_tst = 1'b1; end
            FN_LCLR:  begin dec.known = 1'b1; dec.lam_tst = 1'b1; dec.lam_clr = 1'b1; end
            FN_CTRL:  begin dec.known = 1'b1; dec.wr_ctl = 1'b1; end
            default:  dec = '0;
        endcase
    end
endmodule

// File: rtl/dwr_phase_fsm.sv
module dwr_phase_fsm
    import dwr_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   cyc_start,
    input  logic   req_ok,
    output phase_t ph,
    output logic   take,
    output logic   busy,
    output logic   strobe2
);
    phase_t ph_q, ph_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ph_q <= PH_IDLE;
        else        ph_q <= ph_d;
    end

    always_comb begin
        ph_d = ph_q;
        unique case (ph_q)
            PH_IDLE: if (cyc_start && req_ok) ph_d = PH_ONE;
            PH_ONE:  ph_d = PH_TWO;
            PH_TWO:  ph_d = PH_IDLE;
            default: ph_d = PH_IDLE;
        endcase
    end

    always_comb begin
        ph      = ph_q;
        take    = (ph_q == PH_IDLE) && cyc_start && req_ok;
        busy    = (ph_q == PH_ONE) || (ph_q == PH_TWO);
        strobe2 = (ph_q == PH_TWO);
    end

    // R2
    phase_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_ONE) |=> (ph_q == PH_TWO));
    // R2
    phase_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_TWO) |=> (ph_q == PH_IDLE));
endmodule

// File: rtl/dwr_readout_regs.sv
module dwr_readout_regs
    import dwr_pkg::*;
#(
    parameter int CH_N = 32,
    parameter int DW   = 24,
    localparam int AW  = $clog2(CH_N),
    localparam int PW  = AW + 1
)(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          s2,
    input  fdec_t         dec,
    input  logic          cz,
    input  logic          cc,
    input  logic [DW-1:0] w,
    input  logic          ext_load,
    output logic [PW-1:0] ptr,
    output logic          ld_done,
    output logic          lam,
    output logic          tst
);
    localparam logic [PW-1:0] PEND = PW'(CH_N);

    logic [AW-1:0] start, start_n;
    logic [PW-1:0] ptr_n;
    logic          ld_n, lam_n, len, len_n, tst_n;

    always_comb begin
        ptr_n   = ptr;
        start_n = start;
        ld_n    = ld_done;
        lam_n   = lam;
        len_n   = len;
        tst_n   = tst;
        if (s2 && cz) begin
            ptr_n   = '0;
            start_n = '0;
            ld_n    = 1'b0;
            lam_n   = 1'b0;
            len_n   = 1'b0;
            tst_n   = 1'b0;
        end else begin
            if (s2 && cc) begin
                tst_n = 1'b0;
            end else if (s2) begin
                if (dec.rd_seq && (ptr < PEND)) ptr_n = ptr + PW'(1);
                if (dec.lam_clr) lam_n = 1'b0;
                if (dec.wr_ctl) begin
                    start_n = w[AW-1:0];
                    if (w[PREP_BIT]) begin
                        ptr_n = {1'b0, w[AW-1:0]};
                        len_n = 1'b1;
                    end
                    if (w[LOAD_BIT]) begin
                        ptr_n = {1'b0, w[AW-1:0]};
                        ld_n  = 1'b1;
                        lam_n = lam_n | len_n;
                    end
                    if (w[TEST_BIT]) tst_n = 1'b1;
                end
            end
            if (ext_load) begin
                ptr_n = {1'b0, start_n};
                ld_n  = 1'b1;
                lam_n = lam_n | len_n;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr     <= '0;
            start   <= '0;
            ld_done <= 1'b0;
            lam     <= 1'b0;
            len     <= 1'b0;
            tst     <= 1'b0;
        end else begin
            ptr     <= ptr_n;
            start   <= start_n;
            ld_done <= ld_n;
            lam     <= lam_n;
            len     <= len_n;
            tst     <= tst_n;
        end
    end

    // R5
    ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ptr <= PEND);
    // R5
    seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s2 && !cz && !cc && dec.rd_seq && !ext_load && ptr < PEND)
            |=> (ptr == $past(ptr) + PW'(1)));
    // R10
    init_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s2 && cz) |=> (ptr == '0 && !ld_done && !lam && !tst));
endmodule

// File: rtl/dataway_readout_ctrl.sv
module dataway_readout_ctrl
    import dwr_pkg::*;
#(
    parameter int CH_N = 32,
    parameter int DW   = 24,
    localparam int AW  = $clog2(CH_N),
    localparam int PW  = AW + 1
)(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cyc_start,
    input  logic            stn_sel,
    input  logic [FN_W-1:0] func,
    input  logic [DW-1:0]   wdata,
    input  logic            init_z,
    input  logic            clr_c,
    input  logic            inhibit_i,
    input  logic            ext_load_i,
    input  logic [DW-1:0]   chan_data,
    output logic [AW-1:0]   rd_chan,
    output logic [DW-1:0]   rd_data,
    output logic            x,
    output logic            q,
    output logic            busy,
    output logic            load_p,
    output logic            clear_p,
    output logic            test_p,
    output logic            cnt_inhibit,
    output logic            lam_o
);
    localparam logic [PW-1:0] PEND = PW'(CH_N);

    phase_t          ph;
    logic            take, strobe2;
    logic [FN_W-1:0] fn_q;
    logic [DW-1:0]   w_q;
    logic            z_q, c_q;
    fdec_t           dec;
    logic [PW-1:0]   ptr;
    logic            ld_done, lam, tst;
    logic            bus_fn, in_range;

    dwr_phase_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start),
        .req_ok(stn_sel | init_z | clr_c),
        .ph(ph), .take(take), .busy(busy), .strobe2(strobe2)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fn_q <= '0;
            w_q  <= '0;
            z_q  <= 1'b0;
            c_q  <= 1'b0;
        end else if (take) begin
            fn_q <= func;
            w_q  <= wdata;
            z_q  <= init_z;
            c_q  <= clr_c;
        end
    end

    dwr_func_decode u_dec (.fn(fn_q), .dec(dec));

    dwr_readout_regs #(.CH_N(CH_N), .DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .s2(strobe2), .dec(dec),
        .cz(z_q), .cc(c_q), .w(w_q), .ext_load(ext_load_i),
        .ptr(ptr), .ld_done(ld_done), .lam(lam), .tst(tst)
    );

    always_comb begin
        bus_fn   = busy && !z_q && !c_q;
        in_range = ptr < PEND;
        rd_chan  = ptr[AW-1:0];
        x        = bus_fn && dec.known;
        q        = 1'b0;
        if (bus_fn) begin
            if (dec.rd)           q = ld_done && in_range;
            else if (dec.lam_tst) q = lam;
            else if (dec.wr_ctl)  q = 1'b1;
        end
        rd_data     = (bus_fn && dec.rd) ? chan_data : '0;
        load_p      = strobe2 && !z_q && !c_q && dec.wr_ctl && w_q[LOAD_BIT];
        clear_p     = strobe2 && (z_q || c_q || (dec.wr_ctl && w_q[CLR_BIT]));
        test_p      = strobe2 && !z_q && !c_q && dec.wr_ctl && w_q[TEST_BIT];
        cnt_inhibit = inhibit_i | tst;
        lam_o       = lam;
    end

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!x && !q && rd_data == '0));
    // R2
    pulse_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_p || clear_p || test_p) |-> (ph == PH_TWO));
    // R4
    read_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q && dec.rd) |-> ld_done);
    // R3
    q_needs_x_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q |-> x);
endmodule

// File: tb/dataway_readout_ctrl_test.sv
`timescale 1ns/1ps
module dataway_readout_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cyc_start = 1'b0, stn_sel = 1'b0, init_z = 1'b0, clr_c = 1'b0;
    logic        inhibit_i = 1'b0, ext_load_i = 1'b0;
    logic [4:0]  func = '0;
    logic [23:0] wdata = '0;
    logic [23:0] chan_data;
    logic [4:0]  rd_chan;
    logic [23:0] rd_data;
    logic        x, q, busy, load_p, clear_p, test_p, cnt_inhibit, lam_o;

    int n_run = 0, n_fail = 0, cyc = 0;
    bit running = 0;

    int m_ptr = 0, m_start = 0;
    bit m_ld = 0, m_lam = 0, m_len = 0, m_tst = 0;

    always #2.5 clk = ~clk;

    function automatic logic [23:0] cval(int p);
        return 24'h5A0000 | 24'(p * 7);
    endfunction
    assign chan_data = cval(int'(rd_chan));

    dataway_readout_ctrl uut (
        .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .stn_sel(stn_sel),
        .func(func), .wdata(wdata), .init_z(init_z), .clr_c(clr_c),
        .inhibit_i(inhibit_i), .ext_load_i(ext_load_i), .chan_data(chan_data),
        .rd_chan(rd_chan), .rd_data(rd_data), .x(x), .q(q), .busy(busy),
        .load_p(load_p), .clear_p(clear_p), .test_p(test_p),
        .cnt_inhibit(cnt_inhibit), .lam_o(lam_o)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // every-clock comparison of the persistent state against the model
    always @(negedge clk) begin
        cyc++;
        if (running) begin
            chk("R5 rd_chan", 32'(rd_chan), 32'(m_ptr % 32));
            chk("R9 lam_o", 32'(lam_o), 32'(m_lam));
            chk("R7 cnt_inhibit", 32'(cnt_inhibit), 32'(inhibit_i | m_tst));
        end
    end

    always @(posedge clk) begin
        if (cyc > 20000) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected<=20000", cyc);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    task automatic bus(bit stn, int fn, logic [23:0] w, bit z, bit c, bit poke, string req);
        bit acc, fz, known, ex, eq, el, ec, et;
        logic [23:0] ed;
        acc = stn | z | c;
        fz  = acc && !z && !c;
        known = (fn == 0 || fn == 2 || fn == 8 || fn == 10 || fn == 16);
        ex = fz && known;
        eq = 0;
        if (fz && (fn == 0 || fn == 2)) eq = m_ld && (m_ptr < 32);
        if (fz && (fn == 8 || fn == 10)) eq = m_lam;
        if (fz && fn == 16) eq = 1;
        ed = (fz && (fn == 0 || fn == 2)) ? cval(m_ptr % 32) : 24'h0;
        el = fz && fn == 16 && w[8];
        ec = acc && (z || c || (fn == 16 && w[9]));
        et = fz && fn == 16 && w[11];
        stn_sel = stn; func = 5'(fn); wdata = w; init_z = z; clr_c = c; cyc_start = 1;
        @(posedge clk);
        @(negedge clk);
        cyc_start = 0; stn_sel = 0; init_z = 0; clr_c = 0; func = 5'd16; wdata = 24'hFFFFFF;
        if (poke) begin cyc_start = 1; init_z = 1; end
        chk({req, " x ph1"}, 32'(x), 32'(ex));
        chk({req, " q ph1"}, 32'(q), 32'(eq));
        chk({req, " rd_data ph1"}, 32'(rd_data), 32'(ed));
        chk({req, " pulses ph1"}, {29'd0, load_p, clear_p, test_p}, 32'd0);
        @(posedge clk);
        @(negedge clk);
        cyc_start = 0; init_z = 0;
        chk({req, " x ph2"}, 32'(x), 32'(ex));
        chk({req, " q ph2"}, 32'(q), 32'(eq));
        chk({req, " pulses ph2"}, {29'd0, load_p, clear_p, test_p}, {29'd0, el, ec, et});
        @(posedge clk);
        #1;
        if (acc) begin
            if (z) begin
                m_ptr = 0; m_start = 0; m_ld = 0; m_lam = 0; m_len = 0; m_tst = 0;
            end else if (c) begin
                m_tst = 0;
            end else begin
                if (fn == 2 && m_ptr < 32) m_ptr++;
                if (fn == 10) m_lam = 0;
                if (fn == 16) begin
                    m_start = int'(w[4:0]);
                    if (w[10]) begin m_ptr = m_start; m_len = 1; end
                    if (w[8]) begin m_ptr = m_start; m_ld = 1; m_lam = m_lam | m_len; end
                    if (w[11]) m_tst = 1;
                end
            end
        end
        @(negedge clk);
        chk({req, " idle after"}, {30'd0, busy, x}, 32'd0);
    endtask

    task automatic ext_load();
        ext_load_i = 1;
        @(posedge clk);
        #1;
        m_ptr = m_start; m_ld = 1; m_lam = m_lam | m_len;
        @(negedge clk);
        ext_load_i = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset outputs", {22'd0, rd_chan, busy, x, q, load_p, clear_p, test_p, lam_o, cnt_inhibit}, 32'd0);
        chk("R1 reset rd_data", 32'(rd_data), 32'd0);
        rst_n = 1;
        @(negedge clk);
        running = 1;
        inhibit_i = 1;
        @(negedge clk);
        inhibit_i = 0;
        bus(1, 0, 0, 0, 0, 0, "R4 read before snapshot");
        bus(1, 16, 24'd5, 0, 0, 0, "R6 preset start");
        bus(1, 0, 0, 0, 0, 0, "R4 pointer unchanged by preset");
        ext_load();
        bus(1, 0, 0, 0, 0, 0, "R13 read after external snapshot");
        bus(1, 0, 0, 0, 0, 0, "R4 repeated random read");
        for (int i = 0; i < 3; i++) bus(1, 2, 0, 0, 0, 0, "R5 sequential read");
        bus(1, 16, 24'h00011E, 0, 0, 0, "R6 load at start 30");
        for (int i = 0; i < 4; i++) bus(1, 2, 0, 0, 0, 0, "R5 walk past channel 31");
        bus(1, 0, 0, 0, 0, 0, "R4 random read beyond last channel");
        bus(1, 16, 24'h000402, 0, 0, 0, "R8 prepare start 2");
        bus(1, 8, 0, 0, 0, 0, "R9 lam test clear");
        bus(1, 16, 24'h000102, 0, 0, 1, "R2 load while busy poke");
        bus(1, 8, 0, 0, 0, 0, "R9 lam test set");
        bus(1, 10, 0, 0, 0, 0, "R9 test and clear");
        bus(1, 8, 0, 0, 0, 0, "R9 lam cleared");
        bus(1, 16, 24'h000200, 0, 0, 0, "R7 clear request");
        bus(1, 16, 24'h000803, 0, 0, 0, "R7 test request");
        bus(1, 5, 24'hFFFFFF, 0, 0, 0, "R12 unsupported 5");
        bus(1, 1, 24'hFFFFFF, 0, 0, 0, "R12 unsupported 1");
        bus(0, 2, 0, 0, 0, 0, "R12 no station");
        bus(1, 0, 0, 0, 0, 0, "R12 state intact");
        bus(0, 16, 0, 0, 1, 0, "R11 clear command");
        bus(1, 0, 0, 0, 0, 0, "R11 pointer kept");
        bus(1, 16, 24'h000D07, 0, 0, 0, "R8 prepare plus load");
        bus(1, 2, 0, 0, 0, 0, "R3 seq read");
        bus(1, 16, 24'h000800, 0, 0, 0, "R7 test again");
        bus(0, 0, 0, 1, 0, 0, "R10 initialize");
        bus(1, 0, 0, 0, 0, 0, "R10 read after initialize");
        ext_load();
        bus(1, 0, 0, 0, 0, 0, "R10 start zeroed");
        bus(1, 31, 0, 0, 0, 0, "R3 code 31");
        running = 0;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule